// File: doc/BRIEF.md
# Interrupt and Reset Sequencer for an 8-bit Core

This block sits beside the instruction sequencer of a small 8-bit processor core and decides, at every instruction boundary, whether the core fetches its next opcode or runs an interrupt service sequence. It watches a non-maskable interrupt pin, a group of level-sensitive maskable interrupt lines, the current interrupt-disable flag and the opcode being fetched. When the core reports that an instruction has finished, the block fires a one-cycle service strobe and requests the matching vector.

It also produces the register values to load on a cold (hard) reset or a warm (soft) reset. A cold reset clears the accumulator and index registers and loads fixed stack and status values. A warm reset only moves the stack pointer and masks interrupts. Both kinds of reset cancel anything that is pending and request the reset vector.

The instruction that returns from an interrupt gets special handling. The maskable interrupt is not sampled when that opcode is fetched. It is sampled instead when the instruction completes, using the interrupt-disable flag the instruction has just restored. A pending request is then serviced before any other instruction runs.

Top module: `intr_seq_ctl`

## Requirements
- R1: One cycle after `hard_rst` is sampled high, `ld_regs`, `ld_axy`, `cyc_clr` and `vec_req` are 1, `sp_init` is 0xFD, `p_init` is 0x24 (bit 5 reserved and bit 2 interrupt-disable set, all others clear) and `vec_addr` is 0xFFFC. A hard reset wins over a soft reset in the same cycle.
- R2: One cycle after `soft_rst` is sampled high (without `hard_rst`), `ld_regs`, `cyc_clr` and `vec_req` are 1, `ld_axy` is 0, `sp_init` equals the sampled `sp_now` minus 3 modulo 256, `p_init` equals `p_now` with bit 2 set, and `vec_addr` is 0xFFFC.
- R3: Either reset clears the latched NMI and any scheduled service. An NMI latched before a reset yields no service at the next instruction.
- R4: A rising edge on `nmi_in` is latched. At the next `op_valid`, an NMI is scheduled. In the cycle after the following `inst_end`, `go_nmi` and `vec_req` are 1 and `vec_addr` is 0xFFFA.
- R5: An NMI that is latched or arrives in the same cycle as `op_valid` takes priority over the maskable interrupt. `go_nmi` and `go_irq` are never 1 together.
- R6: At `op_valid`, a maskable interrupt is scheduled only if some `irq_lines` bit is 1, `i_flag` is 0 and `opcode` is not 0x40. One cycle after the following `inst_end`, `go_irq` and `vec_req` are 1 and `vec_addr` is 0xFFFE.
- R7: When the instruction fetched with opcode 0x40 ends, and no NMI was scheduled, `go_irq` is 1 in the next cycle if some `irq_lines` bit is 1 and `i_flag` is 0 in the `inst_end` cycle.
- R8: A service strobe clears the NMI latch and the scheduled-service state. The next instruction, with no new edge and no maskable request, produces neither strobe.
- R9: Holding `nmi_in` high produces only one NMI service. With all `irq_lines` low, no maskable service is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on clear |
| hard_rst | input | 1 | Cold reset request, one cycle |
| soft_rst | input | 1 | Warm reset request, one cycle |
| sp_now | input | DATA_W | Current stack pointer |
| p_now | input | DATA_W | Current status register |
| nmi_in | input | 1 | Non-maskable interrupt pin, edge-sensitive |
| irq_lines | input | IRQ_W | Maskable interrupt request lines, level-sensitive |
| i_flag | input | 1 | Current interrupt-disable flag |
| op_valid | input | 1 | Opcode fetch strobe (instruction boundary) |
| opcode | input | 8 | Opcode being fetched |
| inst_end | input | 1 | Current instruction has completed |
| go_nmi | output | 1 | Start NMI service, one cycle |
| go_irq | output | 1 | Start maskable service, one cycle |
| vec_req | output | 1 | Vector fetch request, one cycle |
| vec_addr | output | ADDR_W | Low byte address of the little-endian vector |
| ld_regs | output | 1 | Load `sp_init` and `p_init` |
| ld_axy | output | 1 | Clear accumulator and index registers |
| sp_init | output | DATA_W | Stack pointer value to load |
| p_init | output | DATA_W | Status value to load |
| cyc_clr | output | 1 | Clear the cycle counter |

## Verification
Each result of the block is registered once. Reset outputs appear one clock after the request is sampled. Service strobes and the vector request appear one clock after `inst_end`. The NMI latch is updated at the same edge that samples the pin. The bench changes inputs on the falling edge and reads outputs on the next falling edge after the deciding rising edge. This keeps each comparison in the one cycle where the pulse is due, and a reference model in the bench predicts which strobe, if any, must show there.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
   localparam logic [7:0] OPC_RETI    = 8'h40;
   localparam int         PBIT_IMASK  = 2;
   localparam int         PBIT_RSVD   = 5;
   localparam logic [7:0] SP_COLD     = 8'hFD;
   localparam int         SP_WARM_DEC = 3;
   localparam int         VEC_NMI_OFS = 5;
   localparam int         VEC_RST_OFS = 3;
   localparam int         VEC_IRQ_OFS = 1;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rst_clr,
   input  logic svc_clr,
   output logic pend_now,
   output logic latch_q
);
   logic pin_q;
   logic edge_now;

   generate
      if (RISING) begin : g_rise
         assign edge_now = pin & ~pin_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= pin;
      end else begin : g_fall
         assign edge_now = ~pin & pin_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pin_q <= 1'b1;
            else        pin_q <= pin;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch_q <= 1'b0;
      else if (rst_clr)  latch_q <= 1'b0;
      else if (edge_now) latch_q <= 1'b1;
      else if (svc_clr)  latch_q <= 1'b0;
   end

   assign pend_now = latch_q | edge_now;

   // R8
   nmi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_clr && !edge_now |=> !latch_q);
   // R3
   nmi_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_clr |=> !latch_q);
endmodule

// File: rtl/rst_state_gen.sv
module rst_state_gen
   import intr_seq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hard_req,
   input  logic              soft_req,
   input  logic [DATA_W-1:0] sp_now,
   input  logic [DATA_W-1:0] p_now,
   output logic              ld_regs,
   output logic              ld_axy,
   output logic [DATA_W-1:0] sp_init,
   output logic [DATA_W-1:0] p_init,
   output logic              cyc_clr
);
   localparam logic [DATA_W-1:0] P_COLD   = DATA_W'((1 << PBIT_RSVD) | (1 << PBIT_IMASK));
   localparam logic [DATA_W-1:0] P_IMASK  = DATA_W'(1 << PBIT_IMASK);
   localparam logic [DATA_W-1:0] SP_RESET = DATA_W'(SP_COLD);
   localparam logic [DATA_W-1:0] SP_DEC   = DATA_W'(SP_WARM_DEC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_regs <= 1'b0;
         ld_axy  <= 1'b0;
         cyc_clr <= 1'b0;
         sp_init <= '0;
         p_init  <= '0;
      end else begin
         ld_regs <= hard_req | soft_req;
         cyc_clr <= hard_req | soft_req;
         ld_axy  <= hard_req;
         if (hard_req) begin
            sp_init <= SP_RESET;
            p_init  <= P_COLD;
         end else if (soft_req) begin
            sp_init <= sp_now - SP_DEC;
            p_init  <= p_now | P_IMASK;
         end
      end
   end

   // R1
   hard_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hard_req |=> ld_regs && ld_axy && sp_init == SP_RESET && p_init == P_COLD);
   // R2
   soft_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_req && !hard_req |=> ld_regs && !ld_axy
                                && sp_init == DATA_W'($past(sp_now) - SP_DEC));
endmodule

// File: rtl/svc_arbiter.sv
module svc_arbiter
   import intr_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_fire,
   input  logic       op_valid,
   input  logic [7:0] opcode,
   input  logic       inst_end,
   input  logic       nmi_pend,
   input  logic       irq_any,
   input  logic       i_flag,
   output logic       take_nmi,
   output logic       take_irq
);
   logic run_nmi, run_irq, reti_mark;
   logic is_reti;

   assign is_reti  = (opcode == OPC_RETI);
   assign take_nmi = inst_end & run_nmi & ~rst_fire;
   assign take_irq = inst_end & ~run_nmi & ~rst_fire &
                     (run_irq | (reti_mark & irq_any & ~i_flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_nmi   <= 1'b0;
         run_irq   <= 1'b0;
         reti_mark <= 1'b0;
      end else if (rst_fire) begin
         run_nmi   <= 1'b0;
         run_irq   <= 1'b0;
         reti_mark <= 1'b0;
      end else begin
         logic n_nmi, n_irq, n_reti;
         n_nmi  = inst_end ? 1'b0 : run_nmi;
         n_irq  = inst_end ? 1'b0 : run_irq;
         n_reti = inst_end ? 1'b0 : reti_mark;
         if (op_valid) begin
            n_nmi  = n_nmi | nmi_pend;
            n_irq  = n_irq | (~nmi_pend & ~is_reti & irq_any & ~i_flag);
            n_reti = n_reti | is_reti;
         end
         run_nmi   <= n_nmi;
         run_irq   <= n_irq;
         reti_mark <= n_reti;
      end
   end

   // R5
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && nmi_pend && !rst_fire |=> run_nmi);
   // R6
   reti_nosample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && is_reti && !run_irq && !rst_fire |=> !run_irq);
   // R3
   rst_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_fire |=> !run_nmi && !run_irq && !reti_mark);
endmodule

// File: rtl/intr_seq_ctl.sv
module intr_seq_ctl
   import intr_seq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 16,
   parameter int IRQ_W      = 4,
   parameter bit NMI_RISING = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hard_rst,
   input  logic              soft_rst,
   input  logic [DATA_W-1:0] sp_now,
   input  logic [DATA_W-1:0] p_now,
   input  logic              nmi_in,
   input  logic [IRQ_W-1:0]  irq_lines,
   input  logic              i_flag,
   input  logic              op_valid,
   input  logic [7:0]        opcode,
   input  logic              inst_end,
   output logic              go_nmi,
   output logic              go_irq,
   output logic              vec_req,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              ld_regs,
   output logic              ld_axy,
   output logic [DATA_W-1:0] sp_init,
   output logic [DATA_W-1:0] p_init,
   output logic              cyc_clr
);
   localparam logic [ADDR_W-1:0] VEC_TOP = '1;
   localparam logic [ADDR_W-1:0] VEC_NMI = VEC_TOP - ADDR_W'(VEC_NMI_OFS);
   localparam logic [ADDR_W-1:0] VEC_RST = VEC_TOP - ADDR_W'(VEC_RST_OFS);
   localparam logic [ADDR_W-1:0] VEC_IRQ = VEC_TOP - ADDR_W'(VEC_IRQ_OFS);

   initial begin
      prm_data_chk: assert (DATA_W >= PBIT_RSVD + 1)
         else $error("DATA_W too narrow for status bits");
      prm_addr_chk: assert (ADDR_W >= 4)
         else $error("ADDR_W too narrow for vectors");
      prm_irq_chk: assert (IRQ_W >= 1)
         else $error("IRQ_W must be at least 1");
   end

   logic rst_fire, irq_any, nmi_pend, nmi_latch, take_nmi, take_irq;

   assign rst_fire = hard_rst | soft_rst;

   generate
      if (IRQ_W == 1) begin : g_irq_one
         assign irq_any = irq_lines[0];
      end else begin : g_irq_many
         assign irq_any = |irq_lines;
      end
   endgenerate

   nmi_edge_latch #(.RISING(NMI_RISING)) u_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (nmi_in),
      .rst_clr  (rst_fire),
      .svc_clr  (take_nmi),
      .pend_now (nmi_pend),
      .latch_q  (nmi_latch)
   );

   svc_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .rst_fire (rst_fire),
      .op_valid (op_valid),
      .opcode   (opcode),
      .inst_end (inst_end),
      .nmi_pend (nmi_pend),
      .irq_any  (irq_any),
      .i_flag   (i_flag),
      .take_nmi (take_nmi),
      .take_irq (take_irq)
   );

   rst_state_gen #(.DATA_W(DATA_W)) u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .hard_req (hard_rst),
      .soft_req (soft_rst),
      .sp_now   (sp_now),
      .p_now    (p_now),
      .ld_regs  (ld_regs),
      .ld_axy   (ld_axy),
      .sp_init  (sp_init),
      .p_init   (p_init),
      .cyc_clr  (cyc_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_nmi   <= 1'b0;
         go_irq   <= 1'b0;
         vec_req  <= 1'b0;
         vec_addr <= '0;
      end else begin
         go_nmi  <= take_nmi;
         go_irq  <= take_irq;
         vec_req <= rst_fire | take_nmi | take_irq;
         if (rst_fire)      vec_addr <= VEC_RST;
         else if (take_nmi) vec_addr <= VEC_NMI;
         else if (take_irq) vec_addr <= VEC_IRQ;
      end
   end

   // R4
   vec_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_nmi |-> vec_req && vec_addr == VEC_NMI);
   // R6
   vec_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_irq |-> vec_req && vec_addr == VEC_IRQ);
   // R5
   one_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({go_nmi, go_irq, ld_regs}));
   // R8
   latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_nmi && !$past(nmi_pend && !nmi_latch) |-> !nmi_latch || $past(nmi_in) == 1'b0);
endmodule

// File: tb/intr_seq_ctl_tb_top.sv
module intr_seq_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hard_rst = 0, soft_rst = 0;
   logic [7:0] sp_now = 0, p_now = 0;
   logic       nmi_in = 0;
   logic [3:0] irq_lines = 0;
   logic       i_flag = 0, op_valid = 0, inst_end = 0;
   logic [7:0] opcode = 0;
   logic       go_nmi, go_irq, vec_req, ld_regs, ld_axy, cyc_clr;
   logic [15:0] vec_addr;
   logic [7:0] sp_init, p_init;

   int total = 0, bad = 0;
   bit done = 0;
   bit mdl_latch = 0;
   bit nmi_prev = 0;

   always #5 clk = ~clk;

   intr_seq_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
      .sp_now(sp_now), .p_now(p_now), .nmi_in(nmi_in), .irq_lines(irq_lines),
      .i_flag(i_flag), .op_valid(op_valid), .opcode(opcode), .inst_end(inst_end),
      .go_nmi(go_nmi), .go_irq(go_irq), .vec_req(vec_req), .vec_addr(vec_addr),
      .ld_regs(ld_regs), .ld_axy(ld_axy), .sp_init(sp_init), .p_init(p_init),
      .cyc_clr(cyc_clr));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // 0 none, 1 nmi, 2 irq
   function automatic int expect_svc(bit pend, bit [7:0] op, bit irq0, bit if0,
                                     bit irq1, bit if1);
      if (pend) return 1;
      if (op != 8'h40 && irq0 && !if0) return 2;
      if (op == 8'h40 && irq1 && !if1) return 2;
      return 0;
   endfunction

   function automatic int vec_of(int kind);
      return (kind == 1) ? 16'hFFFA : 16'hFFFE;
   endfunction

   task automatic instr(input bit [7:0] op, input bit [3:0] irq0, input bit if0,
                        input bit [3:0] irq1, input bit if1,
                        input bit e0, input bit mid, input bit keep, input string tag);
      bit edge0, edge_mid;
      int kind;
      edge0    = (e0 | keep) & !nmi_prev;
      edge_mid = mid & !keep;
      kind = expect_svc(mdl_latch | edge0, op, |irq0, if0, |irq1, if1);
      @(negedge clk);
      op_valid = 1; opcode = op; irq_lines = irq0; i_flag = if0; nmi_in = e0 | keep;
      @(negedge clk);
      op_valid = 0; nmi_in = keep;
      @(negedge clk);
      nmi_in = mid | keep;
      @(negedge clk);
      nmi_in = keep; inst_end = 1; irq_lines = irq1; i_flag = if1;
      @(negedge clk);
      inst_end = 0; irq_lines = 0;
      nmi_prev = keep;
      mdl_latch = (kind == 1) ? 1'b0 : (mdl_latch | edge_mid);
      chk(go_nmi == (kind == 1), {tag, " go_nmi"}, go_nmi, kind == 1);
      chk(go_irq == (kind == 2), {tag, " go_irq"}, go_irq, kind == 2);
      chk(vec_req == (kind != 0), {tag, " vec_req"}, vec_req, kind != 0);
      if (kind != 0)
         chk(vec_addr == vec_of(kind), {tag, " vec_addr"}, vec_addr, vec_of(kind));
   endtask

   task automatic do_reset(input bit h, input bit s, input bit [7:0] sp, input bit [7:0] p,
                           input string tag);
      bit [7:0] esp, ep;
      @(negedge clk);
      hard_rst = h; soft_rst = s; sp_now = sp; p_now = p;
      @(negedge clk);
      hard_rst = 0; soft_rst = 0;
      mdl_latch = 0;
      esp = h ? 8'hFD : 8'(sp - 8'd3);
      ep  = h ? 8'h24 : (p | 8'h04);
      chk(ld_regs == 1, {tag, " ld_regs"}, ld_regs, 1);
      chk(ld_axy == h, {tag, " ld_axy"}, ld_axy, h);
      chk(sp_init == esp, {tag, " sp_init"}, sp_init, esp);
      chk(p_init == ep, {tag, " p_init"}, p_init, ep);
      chk(cyc_clr == 1, {tag, " cyc_clr"}, cyc_clr, 1);
      chk(vec_req && vec_addr == 16'hFFFC, {tag, " vec"}, vec_addr, 16'hFFFC);
      @(negedge clk);
      chk(ld_regs == 0 && vec_req == 0, {tag, " pulse width"}, ld_regs, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #23 rst_n = 1;
      @(negedge clk);
      chk(!go_nmi && !go_irq && !vec_req && !ld_regs, "reset state", vec_req, 0);

      // R1 cold reset, R2 warm reset and wraparound, R1 priority over warm
      do_reset(1, 0, 8'h37, 8'h81, "R1 hard");
      do_reset(0, 1, 8'h01, 8'h81, "R2 soft wrap");
      do_reset(0, 1, 8'h80, 8'h00, "R2 soft");
      do_reset(1, 1, 8'h55, 8'hC3, "R1 both");

      // R4 latched NMI from a mid-instruction edge, taken at next instruction
      instr(8'hEA, 0, 0, 0, 0, 0, 1, 0, "R4 latch only");
      instr(8'hEA, 0, 0, 0, 0, 0, 0, 0, "R4 latched nmi");
      // R5 same-cycle NMI and IRQ
      instr(8'hEA, 4'h3, 0, 4'h3, 0, 1, 0, 0, "R5 same cycle");
      // R8 nothing after service
      instr(8'hEA, 0, 0, 0, 0, 0, 0, 0, "R8 quiet");
      // R6 masked, RTI at fetch, then plain IRQ
      instr(8'hEA, 4'h1, 1, 4'h1, 1, 0, 0, 0, "R6 masked");
      instr(8'h40, 4'h8, 0, 4'h0, 0, 0, 0, 0, "R6 reti no sample");
      instr(8'hEA, 4'h8, 0, 4'h0, 0, 0, 0, 0, "R6 irq");
      // R7 RTI restores clear I with IRQ pending
      instr(8'h40, 4'h0, 1, 4'h2, 0, 0, 0, 0, "R7 after reti");
      instr(8'h40, 4'h2, 1, 4'h2, 1, 0, 0, 0, "R7 reti masked");
      // R9 held NMI
      instr(8'hEA, 0, 0, 0, 0, 0, 0, 1, "R9 held first");
      instr(8'hEA, 0, 0, 0, 0, 0, 0, 1, "R9 held again");
      instr(8'hEA, 0, 0, 0, 0, 0, 0, 0, "R9 release");
      // R3 latched NMI discarded by reset
      instr(8'hEA, 0, 0, 0, 0, 0, 1, 0, "R3 set latch");
      do_reset(0, 1, 8'h20, 8'h00, "R3 soft");
      instr(8'hEA, 0, 0, 0, 0, 0, 0, 0, "R3 after reset");

      for (int i = 0; i < 300; i++) begin
         bit [7:0] op;
         bit [3:0] q0, q1;
         op = ($urandom % 4 == 0) ? 8'h40 : 8'($urandom);
         q0 = ($urandom % 2) ? 4'($urandom) : 4'h0;
         q1 = ($urandom % 2) ? 4'($urandom) : 4'h0;
         instr(op, q0, 1'($urandom % 3 == 0), q1, 1'($urandom % 3 == 0),
               1'($urandom % 5 == 0), 1'($urandom % 6 == 0), 1'b0, "R5 R6 R7 random");
      end

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule